// File: doc/BRIEF.md
# Counter-Addressed Test Point Access

This block lets a design carry many control points and many observation points while spending almost no pins on them. A single serial data pin feeds a bank of control latches; which latch captures the bit is chosen by an internal address counter that steps once per clock. The latched values drive gates inserted on functional nets: some gates can force a net high, some can force a net low, and some can replace the net with a chosen value. The same counter also drives an observation multiplexer that puts one of 2^CNT_W monitor nets on a single output pin.

A two-bit mode input selects the phase. In the normal phase the inserted gates are transparent and nothing moves. In the load phase the counter restarts from zero and one control bit is shifted in per clock, so loading every latch costs one clock per latch before a test vector can be applied. In the test phase the latched values take effect on the functional nets and the counter keeps stepping, scanning the monitor nets across the output one per clock.

Top module: `tpa_top`

## Requirements
- R1: While rst_ni is low, every inserted gate is transparent (func_o equals func_i even with mode 10), the address is 0 and obs_o equals mon_i[0].
- R2: In mode 10, a force-high net i (0 <= i < N_OR) reads func_i[i] OR latch i on func_o[i].
- R3: In mode 10, a force-low net N_OR+j (0 <= j < N_AND) reads func_i AND latch N_OR+j on the same func_o bit.
- R4: In mode 10, a replace net N_OR+N_AND+m (0 <= m < N_MUX) takes latch B+2m when latch B+2m+1 is 1 and follows its func_i bit when that latch is 0, with B = N_OR+N_AND.
- R5: In mode 01, on each rising clock the latch at the current address captures tdata_i; all other latches keep their values, and an address at or above the latch count writes nothing.
- R6: In modes 00, 01 and 11, func_o equals func_i regardless of latch contents, and in every mode other than 01 the latches never change.
- R7: obs_o always equals mon_i at the current address.
- R8: The current address is 0 in the first cycle of mode 01 (the cycle after any other mode or reset) and the counter value otherwise; in modes 01 and 10 the counter becomes the address plus one, wrapping modulo 2^CNT_W, and in modes 00 and 11 it holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Test clock stepping counter and latches |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | 00 normal, 01 load, 10 test, 11 treated as normal |
| tdata_i | input | 1 | Serial control bit captured during load |
| func_i | input | N_OR+N_AND+N_MUX | Functional nets entering the inserted gates |
| func_o | output | N_OR+N_AND+N_MUX | Functional nets after the inserted gates |
| mon_i | input | 2^CNT_W | Monitor nets available for observation |
| obs_o | output | 1 | Currently addressed monitor net |

## Verification
The critical overlap is the cycle where the counter restart and a latch write coincide: switching straight from mode 10 with a non-zero counter into mode 01 must write latch 0, not the stale counter position, while obs_o must already show mon_i[0]. The bench provokes this by leaving test mode mid-scan into a short partial load and by a long stretch of pseudo-random mode changes, then judges it by returning to mode 10 and comparing every func_o bit and obs_o against a behavioural model of latches and counter on every clock.

// File: rtl/tpa_pkg.sv
package tpa_pkg;
  typedef enum logic [1:0] {
    MODE_NORM = 2'b00,
    MODE_LOAD = 2'b01,
    MODE_TEST = 2'b10,
    MODE_RSVD = 2'b11
  } tpa_mode_e;
endpackage

// File: rtl/tpa_addr_cnt.sv
module tpa_addr_cnt
  import tpa_pkg::*;
#(
  parameter int unsigned CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  tpa_mode_e        mode_i,
  output logic [CNT_W-1:0] addr_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             load_prev_q;
  logic             load_first;
  logic             step_en;

  assign load_first = (mode_i == MODE_LOAD) && !load_prev_q;
  assign addr_o     = load_first ? '0 : cnt_q;
  assign step_en    = (mode_i == MODE_LOAD) || (mode_i == MODE_TEST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q       <= '0;
      load_prev_q <= 1'b0;
    end else begin
      if (step_en) cnt_q <= addr_o + 1'b1;
      load_prev_q <= (mode_i == MODE_LOAD);
    end
  end

  AST_CNT_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_LOAD && !load_prev_q) |=> (cnt_q == CNT_W'(1))); // R8
  AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_NORM || mode_i == MODE_RSVD) |=> $stable(cnt_q)); // R8
  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_TEST) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1))); // R8
endmodule

// File: rtl/tpa_ctrl_reg.sv
module tpa_ctrl_reg #(
  parameter int unsigned CNT_W = 3,
  parameter int unsigned N_OR  = 2,
  parameter int unsigned N_AND = 2,
  parameter int unsigned N_MUX = 2,
  localparam int unsigned N_LAT = N_OR + N_AND + 2 * N_MUX
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_en_i,
  input  logic [CNT_W-1:0] addr_i,
  input  logic             data_i,
  output logic [N_LAT-1:0] lat_o
);
  // reset leaves every gate transparent: force-low latches at 1, rest at 0
  localparam logic [N_LAT-1:0] RST_VAL = {{(2*N_MUX){1'b0}}, {N_AND{1'b1}}, {N_OR{1'b0}}};

  logic [N_LAT-1:0] lat_q;
  logic [N_LAT-1:0] wr_en;

  for (genvar i = 0; i < N_LAT; i++) begin : g_wr
    assign wr_en[i] = load_en_i && (addr_i == CNT_W'(i));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_q <= RST_VAL;
    end else begin
      for (int i = 0; i < N_LAT; i++) begin
        if (wr_en[i]) lat_q[i] <= data_i;
      end
    end
  end

  assign lat_o = lat_q;

  AST_ONE_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(wr_en)); // R5
  AST_LAT_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_en_i |=> $stable(lat_q)); // R6
endmodule

// File: rtl/tpa_cp_bank.sv
module tpa_cp_bank #(
  parameter int unsigned N_OR  = 2,
  parameter int unsigned N_AND = 2,
  parameter int unsigned N_MUX = 2,
  localparam int unsigned N_LAT = N_OR + N_AND + 2 * N_MUX,
  localparam int unsigned N_NET = N_OR + N_AND + N_MUX,
  localparam int unsigned MUX_B = N_OR + N_AND
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             test_en_i,
  input  logic [N_LAT-1:0] lat_i,
  input  logic [N_NET-1:0] net_i,
  output logic [N_NET-1:0] net_o
);
  for (genvar i = 0; i < N_OR; i++) begin : g_or
    assign net_o[i] = net_i[i] | (test_en_i & lat_i[i]);

    AST_OR_FORCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (test_en_i && lat_i[i]) |-> net_o[i]); // R2
  end

  for (genvar j = 0; j < N_AND; j++) begin : g_and
    localparam int unsigned K = N_OR + j;
    assign net_o[K] = net_i[K] & (~test_en_i | lat_i[K]);

    AST_AND_FORCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (test_en_i && !lat_i[K]) |-> !net_o[K]); // R3
  end

  for (genvar m = 0; m < N_MUX; m++) begin : g_mux
    localparam int unsigned K = MUX_B + m;
    localparam int unsigned V = MUX_B + 2 * m;
    logic sel;
    assign sel      = test_en_i & lat_i[V+1];
    assign net_o[K] = sel ? lat_i[V] : net_i[K];

    AST_MUX_REPLACE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (test_en_i && lat_i[V+1]) |-> (net_o[K] == lat_i[V])); // R4
  end
endmodule

// File: rtl/tpa_obs_mux.sv
module tpa_obs_mux #(
  parameter int unsigned CNT_W = 3,
  localparam int unsigned N_MON = 2 ** CNT_W
) (
  input  logic [N_MON-1:0] mon_i,
  input  logic [CNT_W-1:0] addr_i,
  output logic             obs_o
);
  assign obs_o = mon_i[addr_i];
endmodule

// File: rtl/tpa_top.sv
module tpa_top
  import tpa_pkg::*;
#(
  parameter int unsigned CNT_W = 3,
  parameter int unsigned N_OR  = 2,
  parameter int unsigned N_AND = 2,
  parameter int unsigned N_MUX = 2,
  localparam int unsigned N_NET = N_OR + N_AND + N_MUX,
  localparam int unsigned N_LAT = N_OR + N_AND + 2 * N_MUX,
  localparam int unsigned N_MON = 2 ** CNT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       mode_i,
  input  logic             tdata_i,
  input  logic [N_NET-1:0] func_i,
  output logic [N_NET-1:0] func_o,
  input  logic [N_MON-1:0] mon_i,
  output logic             obs_o
);
  tpa_mode_e        mode;
  logic [CNT_W-1:0] addr;
  logic [N_LAT-1:0] lat;

  assign mode = tpa_mode_e'(mode_i);

  tpa_addr_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .mode_i (mode),
    .addr_o (addr)
  );

  tpa_ctrl_reg #(.CNT_W(CNT_W), .N_OR(N_OR), .N_AND(N_AND), .N_MUX(N_MUX)) u_lat (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_en_i (mode == MODE_LOAD),
    .addr_i    (addr),
    .data_i    (tdata_i),
    .lat_o     (lat)
  );

  tpa_cp_bank #(.N_OR(N_OR), .N_AND(N_AND), .N_MUX(N_MUX)) u_cp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .test_en_i (mode == MODE_TEST),
    .lat_i     (lat),
    .net_i     (func_i),
    .net_o     (func_o)
  );

  tpa_obs_mux #(.CNT_W(CNT_W)) u_obs (
    .mon_i  (mon_i),
    .addr_i (addr),
    .obs_o  (obs_o)
  );

  AST_PASS_THRU: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode != MODE_TEST) |-> (func_o == func_i)); // R6
endmodule

// File: tb/tpa_top_tb_top.sv
`timescale 1ns/1ps
module tpa_top_tb_top;
  localparam int CNT_W = 3;
  localparam int N_OR  = 2;
  localparam int N_AND = 2;
  localparam int N_MUX = 2;
  localparam int N_NET = N_OR + N_AND + N_MUX;
  localparam int N_LAT = N_OR + N_AND + 2 * N_MUX;
  localparam int N_MON = 2 ** CNT_W;

  logic             clk_i = 1'b0;
  logic             rst_ni;
  logic [1:0]       mode_i;
  logic             tdata_i;
  logic [N_NET-1:0] func_i;
  logic [N_NET-1:0] func_o;
  logic [N_MON-1:0] mon_i;
  logic             obs_o;

  int  checks = 0;
  int  errors = 0;
  bit  done   = 0;

  // behavioural model state
  int  m_cnt;
  bit  m_prev_load;
  bit  m_lat[N_LAT];
  logic [31:0] lfsr = 32'h1ACE_B00C;

  always #2.5 clk_i = ~clk_i;

  tpa_top #(.CNT_W(CNT_W), .N_OR(N_OR), .N_AND(N_AND), .N_MUX(N_MUX)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode_i), .tdata_i(tdata_i),
    .func_i(func_i), .func_o(func_o), .mon_i(mon_i), .obs_o(obs_o)
  );

  function automatic logic [31:0] rnd();
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    return lfsr;
  endfunction

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at %0t: actual %b expected %b", tag, $time, act, exp);
    end
  endtask

  function automatic int cur_addr();
    return (mode_i == 2'b01 && !m_prev_load) ? 0 : m_cnt;
  endfunction

  task automatic compare();
    int a = cur_addr();
    for (int i = 0; i < N_NET; i++) begin
      logic e;
      string tag;
      e = func_i[i];
      if (mode_i != 2'b10) tag = "R6";
      else if (i < N_OR) begin
        tag = "R2,R5"; e = func_i[i] | m_lat[i];
      end else if (i < N_OR + N_AND) begin
        tag = "R3,R5"; e = func_i[i] & m_lat[i];
      end else begin
        int v = N_OR + N_AND + 2 * (i - N_OR - N_AND);
        tag = "R4,R5"; e = m_lat[v+1] ? m_lat[v] : func_i[i];
      end
      check(tag, func_o[i], e);
    end
    check("R7,R8", obs_o, mon_i[a]);
  endtask

  task automatic step(input logic [1:0] md, input logic d);
    int a;
    @(negedge clk_i);
    mode_i  = md;
    tdata_i = d;
    func_i  = N_NET'(rnd());
    mon_i   = N_MON'(rnd());
    #1;
    compare();
    @(posedge clk_i);
    a = cur_addr();
    if (md == 2'b01) begin
      if (a < N_LAT) m_lat[a] = d;
      m_cnt = (a + 1) % N_MON;
    end else if (md == 2'b10) begin
      m_cnt = (m_cnt + 1) % N_MON;
    end
    m_prev_load = (md == 2'b01);
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] pat = 8'b1011_0010;
    rst_ni = 1'b0; mode_i = 2'b10; tdata_i = 1'b0;
    m_cnt = 0; m_prev_load = 0;
    for (int i = 0; i < N_LAT; i++) m_lat[i] = (i >= N_OR && i < N_OR + N_AND);
    for (int k = 0; k < 3; k++) begin
      func_i = N_NET'(rnd()); mon_i = N_MON'(rnd());
      #3;
      for (int i = 0; i < N_NET; i++) check("R1", func_o[i], func_i[i]);
      check("R1", obs_o, mon_i[0]);
    end
    @(negedge clk_i);
    rst_ni = 1'b1;
    mode_i = 2'b00;

    for (int i = 0; i < 3; i++) step(2'b00, 1'b1);
    for (int i = 0; i < N_LAT; i++) step(2'b01, pat[i]);        // full load
    for (int i = 0; i < 12; i++) step(2'b10, 1'b0);             // apply + scan
    for (int i = 0; i < 3; i++) step(2'b00, 1'b1);
    for (int i = 0; i < 2; i++) step(2'b11, 1'b1);
    for (int i = 0; i < 3; i++) step(2'b10, 1'b0);              // counter mid-scan
    for (int i = 0; i < 3; i++) step(2'b01, ~pat[i]);           // restart overlap
    for (int i = 0; i < 6; i++) step(2'b10, 1'b0);
    for (int i = 0; i < 10; i++) step(2'b01, 1'b1);             // wrap past latch count
    for (int i = 0; i < 4; i++) step(2'b10, 1'b0);
    for (int i = 0; i < 400; i++) begin
      logic [31:0] r = rnd();
      step(r[1:0], r[5]);
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule